// File: doc/BRIEF.md
# USB endpoint handshake bank controller

This block holds the control and status state of one USB device endpoint that moves data through two banks used in ping-pong order. For every token the bus side presents, it chooses the handshake (ACK, NAK or STALL, or no answer) from the token kind, the endpoint kind, how full the addressed bank is and a set of firmware-controlled flags. It also tracks the DATA0/DATA1 toggle and the two bank pointers: one pointer for the bus side and one for firmware.

Firmware drives single-cycle set and clear strobes. These force either bank busy, raise or drop a stall request, and restart the toggle at DATA0. Firmware also releases the current bank by clearing the FIFO-control bit. On an IN endpoint this release commits the filled bank for sending. On an OUT endpoint it frees a bank that has been read. In both cases the firmware pointer then moves to the other bank. A status byte reports the flags, the pointers and the toggle. The serializer, CRC, the bank memory and the bus interface sit outside this block.

Top module: `ep_hs_ctrl`

## Requirements
- R1: After a synchronous reset, hs_valid, hs_code, hs_data1, hs_bank and rx_keep are 0. Every flag, pointer, bank-full bit and the toggle is 0. ep_status therefore reads 8'h01 for an IN endpoint and 8'h00 for the other kinds.
- R2: busy_set[b] makes bank b busy and busy_clr[b] makes it not busy. Bank 0 reads in ep_status[3] and bank 1 in ep_status[4].
- R3: When the bank addressed by the bus pointer is busy, every IN or OUT token that would otherwise get ACK or NAK gets NAK (hs_code 2). SETUP is not affected by busy.
- R4: stall_set raises the stall request (ep_status[1]) and stall_clr drops it. While the request is up, IN and OUT tokens get STALL (hs_code 3). STALL takes priority over NAK, and NAK takes priority over ACK (hs_code 1).
- R5: On a control endpoint, a SETUP token always gets ACK with rx_keep 1. It drops the stall request and sets the toggle to 1. On IN and OUT endpoints, SETUP gets no answer.
- R6: tog_rst sets the toggle (ep_status[7]) to 0 and wins over any toggle change in the same cycle. ep_status[2] always reads 0.
- R7: The toggle flips after each ACKed IN token and after each ACKed OUT token whose data PID (tok_data1) equals the toggle. An ACKed OUT token whose PID differs from the toggle has rx_keep 0 and changes neither the toggle nor any bank.
- R8: IN endpoint (cfg_ep_type 1): the FIFO-control bit (ep_status[0]) is 1 while the firmware bank is empty. Clearing it marks that bank full and flips the firmware pointer (ep_status[5]). An IN token to an empty bus bank gets NAK. An ACKed IN token empties that bank and flips the bus pointer (ep_status[6]).
- R9: OUT endpoint (cfg_ep_type 2): the FIFO-control bit is 1 while the firmware bank is full. Clearing it empties that bank and flips the firmware pointer. An OUT token to a full bus bank gets NAK. A kept OUT packet fills that bank and flips the bus pointer.
- R10: Control endpoint (cfg_ep_type 0 or 3): the FIFO-control bit reads 0, fifocon_clr has no effect, and both pointers stay at 0.
- R11: When a set and a clear strobe for the same bit arrive together, the bit ends up 0. A SETUP counts as a stall clear.
- R12: The answer to a token on tok_valid appears on hs_valid/hs_code one clock later. Token kinds are 0 SETUP, 1 IN, 2 OUT and 3 ignored. IN or OUT tokens to an endpoint of the other direction get no answer (hs_valid 0, hs_code 0).
- R13: With a valid answer, hs_data1 carries the toggle used for an IN or OUT token and 0 for SETUP. hs_bank carries the bus bank that was addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ep_type | input | 2 | Endpoint kind: 0 control, 1 IN, 2 OUT, 3 control |
| tok_valid | input | 1 | A token is presented this cycle |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT, 3 ignored |
| tok_data1 | input | 1 | PID of the received data packet is DATA1 |
| busy_set | input | 2 | Per-bank busy set strobes |
| busy_clr | input | 2 | Per-bank busy clear strobes |
| stall_set | input | 1 | Stall request set strobe |
| stall_clr | input | 1 | Stall request clear strobe |
| tog_rst | input | 1 | Restart the toggle at DATA0 |
| fifocon_clr | input | 1 | Firmware releases its current bank |
| hs_valid | output | 1 | An answer is given |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| hs_data1 | output | 1 | Toggle used by the answered transfer |
| hs_bank | output | 1 | Bus bank addressed by the answered transfer |
| rx_keep | output | 1 | Received data is committed to the bank |
| ep_status | output | 8 | {toggle, bus ptr, fw ptr, busy1, busy0, 0, stall, FIFO-control} |

## Verification
The bench targets the same-cycle conflicts. A set and a clear strobe together must leave the bit at 0; a design that lets the set win keeps a bank busy for good. A SETUP in the same cycle as stall_set must still drop the stall; a design that gets this wrong keeps answering STALL after the host has recovered. Other cases are an OUT packet with the wrong toggle (a faulty design fills the bank or flips the toggle and so loses the next packet) and both banks full (a faulty design answers ACK and overwrites data). fifocon_clr pulses while the FIFO-control bit is 0, and on control endpoints, must change nothing; a design that acts on them lets the two pointers drift apart.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    localparam int EP_BANKS = 2;
    localparam int BANK_W   = (EP_BANKS > 1) ? $clog2(EP_BANKS) : 1;

    typedef enum logic [1:0] {
        EPT_CTRL = 2'd0,
        EPT_IN   = 2'd1,
        EPT_OUT  = 2'd2,
        EPT_CTL2 = 2'd3
    } ep_type_e;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2,
        TK_NONE  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef struct packed {
        logic       tog;
        logic       usb_bank;
        logic       cpu_bank;
        logic [1:0] busy;
        logic       tog_rst_rd;
        logic       stall;
        logic       fifocon;
    } ep_stat_t;

    function automatic logic is_ctrl(ep_type_e t);
        return !(t == EPT_IN || t == EPT_OUT);
    endfunction

    // Priority: no answer for foreign tokens, then STALL, NAK, ACK.
    function automatic hs_e pick_hs(tok_e k, ep_type_e t, logic stall,
                                    logic busy, logic full);
        logic ctl;
        ctl = is_ctrl(t);
        if (k == TK_SETUP) return ctl ? HS_ACK : HS_NONE;
        if (k == TK_NONE) return HS_NONE;
        if (!ctl && ((k == TK_IN) != (t == EPT_IN))) return HS_NONE;
        if (stall) return HS_STALL;
        if (busy) return HS_NAK;
        if (!ctl && ((k == TK_IN) ? !full : full)) return HS_NAK;
        return HS_ACK;
    endfunction

endpackage

// File: rtl/ep_flag_regs.sv
module ep_flag_regs
    import ep_hs_pkg::*;
#(
    parameter int NB = EP_BANKS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] busy_set,
    input  logic [NB-1:0] busy_clr,
    input  logic          stall_set,
    input  logic          stall_clr,
    input  logic          setup_seen,
    output logic [NB-1:0] busy,
    output logic          stall
);

    for (genvar b = 0; b < NB; b++) begin : g_busy
        always_ff @(posedge clk) begin
            if (rst)              busy[b] <= 1'b0;
            else if (busy_clr[b]) busy[b] <= 1'b0;
            else if (busy_set[b]) busy[b] <= 1'b1;
        end

        assert_busy_clr_wins_R11: assert property (@(posedge clk) disable iff (rst)
            (busy_set[b] && busy_clr[b]) |=> !busy[b]);
    end

    always_ff @(posedge clk) begin
        if (rst)                          stall <= 1'b0;
        else if (stall_clr || setup_seen) stall <= 1'b0;
        else if (stall_set)               stall <= 1'b1;
    end

endmodule

// File: rtl/ep_toggle.sv
module ep_toggle (
    input  logic clk,
    input  logic rst,
    input  logic tog_rst,
    input  logic tog_set1,
    input  logic tog_flip,
    output logic tog
);

    always_ff @(posedge clk) begin
        if (rst)           tog <= 1'b0;
        else if (tog_rst)  tog <= 1'b0;
        else if (tog_set1) tog <= 1'b1;
        else if (tog_flip) tog <= ~tog;
    end

    assert_tog_restart_R6: assert property (@(posedge clk) disable iff (rst)
        tog_rst |=> !tog);

endmodule

// File: rtl/ep_bank_track.sv
module ep_bank_track
    import ep_hs_pkg::*;
#(
    parameter int NB = EP_BANKS,
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ep_type_e      ep_type,
    input  logic          usb_adv,
    input  logic          fifo_rel,
    output logic [NB-1:0] full,
    output logic [BW-1:0] usb_bank,
    output logic [BW-1:0] cpu_bank,
    output logic          fifocon
);

    localparam logic [BW-1:0] LAST = BW'(NB - 1);

    logic ctl, is_in, rel;

    assign ctl     = is_ctrl(ep_type);
    assign is_in   = (ep_type == EPT_IN);
    assign fifocon = ctl ? 1'b0 : (is_in ? !full[cpu_bank] : full[cpu_bank]);
    assign rel     = fifo_rel && fifocon;

    for (genvar b = 0; b < NB; b++) begin : g_full
        always_ff @(posedge clk) begin
            if (rst)                                  full[b] <= 1'b0;
            else if (rel && cpu_bank == BW'(b))       full[b] <= is_in;
            else if (usb_adv && usb_bank == BW'(b))   full[b] <= !is_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            usb_bank <= '0;
            cpu_bank <= '0;
        end else begin
            if (usb_adv) usb_bank <= (usb_bank == LAST) ? '0 : usb_bank + 1'b1;
            if (rel)     cpu_bank <= (cpu_bank == LAST) ? '0 : cpu_bank + 1'b1;
        end
    end

    assert_fifo_rel_moves_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_rel && !ctl && (is_in ? !full[cpu_bank] : full[cpu_bank]))
        |=> (cpu_bank != $past(cpu_bank)));

    assert_ctrl_ptr_still_R10: assert property (@(posedge clk) disable iff (rst)
        ctl |=> $stable(cpu_bank) || $past(rst));

endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
    import ep_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_ep_type,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       tok_data1,
    input  logic [1:0] busy_set,
    input  logic [1:0] busy_clr,
    input  logic       stall_set,
    input  logic       stall_clr,
    input  logic       tog_rst,
    input  logic       fifocon_clr,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    output logic       hs_data1,
    output logic       hs_bank,
    output logic       rx_keep,
    output logic [7:0] ep_status
);

    ep_type_e            ept;
    tok_e                tk;
    hs_e                 hs_n;
    logic                ctl, ack, setup_ok, match, keep, flip, usb_adv;
    logic                stall, tog, fifocon;
    logic [EP_BANKS-1:0] busy_vec, full_vec;
    logic [BANK_W-1:0]   usb_bank, cpu_bank;
    ep_stat_t            st;

    assign ept = ep_type_e'(cfg_ep_type);
    assign tk  = tok_e'(tok_kind);
    assign ctl = is_ctrl(ept);

    assign hs_n = tok_valid ? pick_hs(tk, ept, stall, busy_vec[usb_bank],
                                      full_vec[usb_bank]) : HS_NONE;

    assign ack      = (hs_n == HS_ACK);
    assign match    = (tok_data1 == tog);
    assign setup_ok = ack && (tk == TK_SETUP);
    assign keep     = setup_ok || (ack && tk == TK_OUT && match);
    assign flip     = ack && (tk == TK_IN || (tk == TK_OUT && match));
    assign usb_adv  = !ctl && flip;

    ep_flag_regs #(.NB(EP_BANKS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .busy_set  (busy_set),
        .busy_clr  (busy_clr),
        .stall_set (stall_set),
        .stall_clr (stall_clr),
        .setup_seen(setup_ok),
        .busy      (busy_vec),
        .stall     (stall)
    );

    ep_toggle u_tog (
        .clk     (clk),
        .rst     (rst),
        .tog_rst (tog_rst),
        .tog_set1(setup_ok),
        .tog_flip(flip),
        .tog     (tog)
    );

    ep_bank_track #(.NB(EP_BANKS), .BW(BANK_W)) u_banks (
        .clk     (clk),
        .rst     (rst),
        .ep_type (ept),
        .usb_adv (usb_adv),
        .fifo_rel(fifocon_clr),
        .full    (full_vec),
        .usb_bank(usb_bank),
        .cpu_bank(cpu_bank),
        .fifocon (fifocon)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
            hs_data1 <= 1'b0;
            hs_bank  <= 1'b0;
            rx_keep  <= 1'b0;
        end else begin
            hs_valid <= (hs_n != HS_NONE);
            hs_code  <= hs_n;
            hs_data1 <= (hs_n != HS_NONE) && (tk != TK_SETUP) && tog;
            hs_bank  <= (hs_n != HS_NONE) ? usb_bank[0] : 1'b0;
            rx_keep  <= keep;
        end
    end

    always_comb begin
        st            = '0;
        st.tog        = tog;
        st.usb_bank   = usb_bank[0];
        st.cpu_bank   = cpu_bank[0];
        st.busy       = busy_vec;
        st.tog_rst_rd = 1'b0;
        st.stall      = stall;
        st.fifocon    = fifocon;
    end
    assign ep_status = st;

    assert_stall_has_req_R4: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == HS_STALL) |-> $past(stall));

    assert_setup_drops_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tk == TK_SETUP && ctl) |=> !stall);

    assert_busy_blocks_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == HS_ACK && $past(tk) != TK_SETUP)
        |-> !$past(busy_vec[usb_bank]));

    assert_in_ack_has_data_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == HS_ACK && ept == EPT_IN && $past(ept) == EPT_IN)
        |-> $past(full_vec[usb_bank]));

    assert_answer_has_token_R12: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(tok_valid));

endmodule

// File: tb/tb_ep_hs_ctrl.sv
`timescale 1ns/1ps
module tb_ep_hs_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_ep_type = 2'd0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       tok_data1 = 1'b0;
    logic [1:0] busy_set = 2'b00;
    logic [1:0] busy_clr = 2'b00;
    logic       stall_set = 1'b0;
    logic       stall_clr = 1'b0;
    logic       tog_rst = 1'b0;
    logic       fifocon_clr = 1'b0;
    logic       hs_valid, hs_data1, hs_bank, rx_keep;
    logic [1:0] hs_code;
    logic [7:0] ep_status;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ep_hs_ctrl dut (
        .clk(clk), .rst(rst), .cfg_ep_type(cfg_ep_type),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_data1(tok_data1),
        .busy_set(busy_set), .busy_clr(busy_clr),
        .stall_set(stall_set), .stall_clr(stall_clr),
        .tog_rst(tog_rst), .fifocon_clr(fifocon_clr),
        .hs_valid(hs_valid), .hs_code(hs_code), .hs_data1(hs_data1),
        .hs_bank(hs_bank), .rx_keep(rx_keep), .ep_status(ep_status)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit m_busy[2];
    bit m_full[2];
    bit m_stall, m_tog, m_cpu, m_usb;
    int m_hc;
    bit m_hv, m_pid, m_bk, m_keep;
    bit x_in, x_out, x_ctl, x_ack, x_match, x_fc, x_data;
    int x_k, x_code;
    bit o_usb, o_cpu;

    always @(posedge clk) begin
        if (rst) begin
            m_busy[0] = 0; m_busy[1] = 0; m_full[0] = 0; m_full[1] = 0;
            m_stall = 0; m_tog = 0; m_cpu = 0; m_usb = 0;
            m_hv = 0; m_hc = 0; m_pid = 0; m_bk = 0; m_keep = 0;
        end else begin
            x_in  = (cfg_ep_type == 2'd1);
            x_out = (cfg_ep_type == 2'd2);
            x_ctl = !x_in && !x_out;
            x_k   = tok_kind;
            x_code = 0;
            if (tok_valid) begin
                if (x_k == 0)                         x_code = x_ctl ? 1 : 0;
                else if (x_k == 3)                    x_code = 0;
                else if (!x_ctl && ((x_k == 1 && !x_in) || (x_k == 2 && !x_out))) x_code = 0;
                else if (m_stall)                     x_code = 3;
                else if (m_busy[m_usb])               x_code = 2;
                else if (x_in && !m_full[m_usb])      x_code = 2;
                else if (x_out && m_full[m_usb])      x_code = 2;
                else                                  x_code = 1;
            end
            x_ack   = (x_code == 1);
            x_match = (tok_data1 == m_tog);
            x_data  = x_ack && (x_k == 1 || (x_k == 2 && x_match));
            x_fc    = x_ctl ? 0 : (x_in ? !m_full[m_cpu] : m_full[m_cpu]);
            m_hv    = (x_code != 0);
            m_hc    = x_code;
            m_pid   = (x_code != 0 && x_k != 0) ? m_tog : 0;
            m_bk    = (x_code != 0) ? m_usb : 0;
            m_keep  = x_ack && (x_k == 0 || (x_k == 2 && x_match));
            o_usb = m_usb; o_cpu = m_cpu;
            if (!x_ctl && x_data) begin m_full[o_usb] = x_out; m_usb = !o_usb; end
            if (fifocon_clr && x_fc) begin m_full[o_cpu] = x_in; m_cpu = !o_cpu; end
            if (tog_rst)                 m_tog = 0;
            else if (x_ack && x_k == 0)  m_tog = 1;
            else if (x_data)             m_tog = !m_tog;
            if (stall_clr || (x_ack && x_k == 0)) m_stall = 0;
            else if (stall_set)                   m_stall = 1;
            for (int b = 0; b < 2; b++) begin
                if (busy_clr[b])      m_busy[b] = 0;
                else if (busy_set[b]) m_busy[b] = 1;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        bit fc;
        if (!rst && cycles > 2) begin
            fc = (cfg_ep_type == 2'd1) ? !m_full[m_cpu] :
                 (cfg_ep_type == 2'd2) ?  m_full[m_cpu] : 1'b0;
            chk("R12 hs_valid", hs_valid, m_hv);
            chk("R3 hs_code", hs_code, m_hc);
            chk("R13 hs_data1", hs_data1, m_pid);
            chk("R13 hs_bank", hs_bank, m_bk);
            chk("R7 rx_keep", rx_keep, m_keep);
            chk(cfg_ep_type == 2'd1 ? "R8 fifocon" :
                cfg_ep_type == 2'd2 ? "R9 fifocon" : "R10 fifocon", ep_status[0], fc);
            chk("R4 stall", ep_status[1], m_stall);
            chk("R6 reset-toggle bit", ep_status[2], 0);
            chk("R2 busy0", ep_status[3], m_busy[0]);
            chk("R2 busy1", ep_status[4], m_busy[1]);
            chk("R8 fw pointer", ep_status[5], m_cpu);
            chk("R9 bus pointer", ep_status[6], m_usb);
            chk("R7 toggle", ep_status[7], m_tog);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        tok_valid = 0; busy_set = 0; busy_clr = 0; stall_set = 0;
        stall_clr = 0; tog_rst = 0; fifocon_clr = 0;
    endtask

    task automatic tok(int k, bit d1);
        tok_valid = 1; tok_kind = 2'(k); tok_data1 = d1;
    endtask

    task automatic do_reset(int t);
        rst = 1; cfg_ep_type = 2'(t);
        repeat (3) step();
        rst = 0;
    endtask

    task automatic rand_run(int n);
        for (int i = 0; i < n; i++) begin
            tok_valid   = ($urandom_range(1) == 1);
            tok_kind    = 2'($urandom_range(3));
            tok_data1   = 1'($urandom_range(1));
            busy_set    = {($urandom_range(15) == 0), ($urandom_range(15) == 0)};
            busy_clr    = {($urandom_range(5) == 0), ($urandom_range(5) == 0)};
            stall_set   = ($urandom_range(31) == 0);
            stall_clr   = ($urandom_range(5) == 0);
            tog_rst     = ($urandom_range(31) == 0);
            fifocon_clr = ($urandom_range(2) == 0);
            step();
        end
    endtask

    initial begin
        // Control endpoint
        do_reset(0);
        chk("R1 status ctrl", ep_status, 8'h00);
        chk("R1 hs_valid", hs_valid, 0);
        busy_set = 2'b01; step();
        chk("R2 busy0 set", ep_status[3], 1);
        tok(1, 0); step();
        chk("R3 IN to busy bank NAK", hs_code, 2);
        tok(0, 0); step();
        chk("R5 SETUP ignores busy", hs_code, 1);
        chk("R5 SETUP keeps data", rx_keep, 1);
        chk("R5 toggle after SETUP", ep_status[7], 1);
        busy_clr = 2'b01; step();
        busy_set = 2'b10; step();
        busy_set = 2'b10; busy_clr = 2'b10; step();
        chk("R11 busy1 clear wins", ep_status[4], 0);
        stall_set = 1; step();
        tok(2, 1); step();
        chk("R4 STALL over ACK", hs_code, 3);
        stall_set = 1; tok(0, 0); step();
        chk("R11 SETUP beats stall set", ep_status[1], 0);
        tog_rst = 1; step();
        chk("R6 toggle restarted", ep_status[7], 0);
        tok(2, 1); step();
        chk("R7 wrong PID still ACK", hs_code, 1);
        chk("R7 wrong PID dropped", rx_keep, 0);
        chk("R7 toggle unchanged", ep_status[7], 0);
        fifocon_clr = 1; step();
        chk("R10 fifocon stays 0", ep_status[0], 0);
        chk("R10 pointer still", ep_status[5], 0);
        tok(2, 1); step();
        chk("R12 OUT to ctrl answered", hs_valid, 1);
        rand_run(1500);

        // IN endpoint
        do_reset(1);
        chk("R1 status IN", ep_status, 8'h01);
        tok(1, 0); step();
        chk("R8 IN to empty bank NAK", hs_code, 2);
        tok(2, 0); step();
        chk("R12 OUT to IN ep ignored", hs_valid, 0);
        fifocon_clr = 1; step();
        chk("R8 fw pointer moved", ep_status[5], 1);
        chk("R8 fifocon for bank1", ep_status[0], 1);
        fifocon_clr = 1; step();
        chk("R8 both full", ep_status[0], 0);
        tok(1, 0); step();
        chk("R8 IN ACK", hs_code, 1);
        chk("R13 IN uses DATA0", hs_data1, 0);
        chk("R8 bus pointer moved", ep_status[6], 1);
        tok(1, 0); step();
        chk("R13 second IN DATA1", hs_data1, 1);
        chk("R13 second IN bank", hs_bank, 1);
        rand_run(1500);

        // OUT endpoint
        do_reset(2);
        chk("R1 status OUT", ep_status, 8'h00);
        tok(2, 0); step();
        chk("R9 OUT ACK", hs_code, 1);
        chk("R9 OUT kept", rx_keep, 1);
        chk("R9 fifocon after fill", ep_status[0], 1);
        tok(2, 1); step();
        tok(2, 0); step();
        chk("R9 both full NAK", hs_code, 2);
        tok(0, 0); step();
        chk("R5 SETUP on OUT ep ignored", hs_valid, 0);
        fifocon_clr = 1; step();
        chk("R9 fifocon after free", ep_status[0], 1);
        chk("R9 fw pointer moved", ep_status[5], 1);
        rand_run(1500);

        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule